// File: doc/BRIEF.md
# Vetoable Burst Sample Memory Controller

This block collects the digitised samples of a single pixel during a burst and hands them out as one serial stream in the quiet gap that follows. A small controller moves between three states: idle, acquiring and reading out. While acquiring, each valid sample lands at the next free address of a local storage array. The fill count tells how many words are committed. A veto strobe given with a sample keeps the write pointer where it is. The stored word then only holds its slot until the next sample replaces it, so rejected events take up no storage.

When the burst ends the controller streams the committed words out, one bit per readout clock enable. It sends a one-step frame marker, then every word from address 0 upward, most significant bit first. It then clears the pointer and returns to idle. A burst start that arrives during readout raises an error pulse. It is remembered and takes effect once the stream is complete. Depth and word width are parameters (640 words of 9 bits by default).

Top module: `burst_sample_store`

## Requirements
- R1: After reset the block is idle: fill_count is 0, and mem_full, start_err, ser_out and ser_frame are all 0.
- R2: While idle, smp_valid, smp_veto and burst_end have no effect: fill_count stays 0, and rd_ce steps produce no frame marker.
- R3: During acquisition, a cycle with smp_valid high and smp_veto low stores smp_data at address fill_count, and fill_count is one higher in the next cycle.
- R4: A sample given with smp_veto high is written at address fill_count but leaves fill_count unchanged, so the next sample overwrites it. A vetoed last sample is not read out.
- R5: fill_count never exceeds DEPTH. Once it equals DEPTH, mem_full is high and further samples are dropped without changing any stored word or the count.
- R6: burst_end during acquisition starts readout (a sample in the same cycle is still taken). Samples given during readout, and burst_start given during acquisition, are ignored.
- R7: In readout, each cycle with rd_ce high advances the stream by one step. The first step drives ser_frame=1 and ser_out=0. The next fill_count×WORD_W steps drive ser_frame=0 and the bits of words 0, 1, … in order, each word most significant bit first. Between steps both outputs hold.
- R8: The step after the last bit drives both serial outputs to 0, clears fill_count to 0 and ends readout.
- R9: burst_start during readout makes start_err high for exactly one cycle, in the cycle after it. Readout continues unchanged, and after it ends acquisition begins at once, without a new burst_start.
- R10: A burst with no committed word reads out as the marker step followed directly by the closing step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| burst_start | input | 1 | Begin acquisition |
| burst_end | input | 1 | End acquisition, begin readout |
| smp_valid | input | 1 | A converted sample is present |
| smp_data | input | WORD_W | Sample value |
| smp_veto | input | 1 | Discard this sample: do not advance the pointer |
| rd_ce | input | 1 | Readout step enable |
| ser_out | output | 1 | Serial data bit |
| ser_frame | output | 1 | Frame marker, high on the first readout step |
| fill_count | output | $clog2(DEPTH+1) | Number of committed words |
| mem_full | output | 1 | Storage is full |
| start_err | output | 1 | One-cycle pulse: burst start arrived during readout |

## Verification
The bench probes veto patterns that leave a vetoed sample last or veto every sample. A design that advanced on veto, or read out the unconfirmed slot, would show a wrong count or an extra word. It fills the array to exactly DEPTH and pushes more samples. Wrapping or counting past the limit would corrupt address 0 or the count. It sends a burst start in the middle of readout to check the one-cycle error, the unbroken stream and the deferred acquisition into address 0. It also checks the empty burst, where a design that mishandled a zero count would run through the array.

// File: rtl/bss_pkg.sv
package bss_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ACQ  = 2'd1,
      ST_RD   = 2'd2
   } bss_state_e;
endpackage

// File: rtl/bss_wr_ctrl.sv
module bss_wr_ctrl #(
   parameter int DEPTH = 640,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          acq,
   input  logic          smp_valid,
   input  logic          smp_veto,
   input  logic          clr,
   output logic          wr_en,
   output logic [AW-1:0] wr_addr,
   output logic [CW-1:0] fill,
   output logic          full
);
   localparam logic [CW-1:0] LIMIT = CW'(DEPTH);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("bss_wr_ctrl: DEPTH must be at least 2");
      end
   endgenerate

   assign full    = (fill == LIMIT);
   assign wr_en   = acq && smp_valid && !full;
   assign wr_addr = fill[AW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill <= '0;
      end else if (clr) begin
         fill <= '0;
      end else if (wr_en && !smp_veto) begin
         fill <= fill + CW'(1);
      end
   end

   // R5
   fill_le_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= LIMIT);

   // R4
   veto_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acq && smp_valid && smp_veto && !clr) |=> (fill == $past(fill)));

   // R3
   advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acq && smp_valid && !smp_veto && !full && !clr) |=> (fill == $past(fill) + CW'(1)));
endmodule

// File: rtl/bss_store.sv
module bss_store #(
   parameter int DEPTH  = 640,
   parameter int WORD_W = 9,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [AW-1:0]     rd_addr,
   output logic [WORD_W-1:0] rd_word
);
   generate
      if (WORD_W < 1) begin : g_bad_width
         $error("bss_store: WORD_W must be positive");
      end
   endgenerate

   logic [WORD_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         cells[wr_addr] <= wr_data;
      end
   end

   assign rd_word = (int'(rd_addr) < DEPTH) ? cells[rd_addr] : '0;
endmodule

// File: rtl/bss_serializer.sv
module bss_serializer #(
   parameter int DEPTH     = 640,
   parameter int WORD_W    = 9,
   parameter bit MSB_FIRST = 1'b1,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1),
   localparam int BW = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              step,
   input  logic [CW-1:0]     count,
   input  logic [WORD_W-1:0] rd_word,
   output logic [AW-1:0]     rd_addr,
   output logic              ser_out,
   output logic              ser_frame,
   output logic              done
);
   localparam logic [BW-1:0] LAST = BW'(WORD_W - 1);

   logic          marked;
   logic [BW-1:0] bit_idx;
   logic [CW-1:0] word_idx;
   logic          cur_bit;

   generate
      if (MSB_FIRST) begin : g_msb
         assign cur_bit = rd_word[LAST - bit_idx];
      end else begin : g_lsb
         assign cur_bit = rd_word[bit_idx];
      end
   endgenerate

   assign rd_addr = word_idx[AW-1:0];
   assign done    = active && step && marked && (word_idx == count);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         marked    <= 1'b0;
         bit_idx   <= '0;
         word_idx  <= '0;
         ser_out   <= 1'b0;
         ser_frame <= 1'b0;
      end else if (!active) begin
         marked    <= 1'b0;
         bit_idx   <= '0;
         word_idx  <= '0;
         ser_out   <= 1'b0;
         ser_frame <= 1'b0;
      end else if (step) begin
         if (!marked) begin
            marked    <= 1'b1;
            ser_frame <= 1'b1;
            ser_out   <= 1'b0;
         end else if (word_idx == count) begin
            ser_frame <= 1'b0;
            ser_out   <= 1'b0;
         end else begin
            ser_frame <= 1'b0;
            ser_out   <= cur_bit;
            if (bit_idx == LAST) begin
               bit_idx  <= '0;
               word_idx <= word_idx + CW'(1);
            end else begin
               bit_idx <= bit_idx + BW'(1);
            end
         end
      end
   end

   // R7
   marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && step && !marked) |=> ser_frame);

   // R7
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !step) |=> ($stable(ser_out) && $stable(ser_frame)));

   // R8
   quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!active || done) |=> (!ser_out && !ser_frame));
endmodule

// File: rtl/burst_sample_store.sv
module burst_sample_store #(
   parameter int DEPTH     = 640,
   parameter int WORD_W    = 9,
   parameter bit MSB_FIRST = 1'b1,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              burst_start,
   input  logic              burst_end,
   input  logic              smp_valid,
   input  logic [WORD_W-1:0] smp_data,
   input  logic              smp_veto,
   input  logic              rd_ce,
   output logic              ser_out,
   output logic              ser_frame,
   output logic [CW-1:0]     fill_count,
   output logic              mem_full,
   output logic              start_err
);
   import bss_pkg::*;

   bss_state_e        state, state_nx;
   logic              start_pend;
   logic              wr_en;
   logic [AW-1:0]     wr_addr;
   logic [AW-1:0]     rd_addr;
   logic [WORD_W-1:0] rd_word;
   logic              rd_done;
   logic              in_acq, in_rd;

   assign in_acq = (state == ST_ACQ);
   assign in_rd  = (state == ST_RD);

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE: if (burst_start) state_nx = ST_ACQ;
         ST_ACQ:  if (burst_end)   state_nx = ST_RD;
         ST_RD:   if (rd_done)     state_nx = (start_pend || burst_start) ? ST_ACQ : ST_IDLE;
         default: state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         start_pend <= 1'b0;
         start_err  <= 1'b0;
      end else begin
         state     <= state_nx;
         start_err <= in_rd && burst_start;
         if (!in_rd || rd_done) begin
            start_pend <= 1'b0;
         end else if (burst_start) begin
            start_pend <= 1'b1;
         end
      end
   end

   bss_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
      .clk      (clk),
      .rst_n    (rst_n),
      .acq      (in_acq),
      .smp_valid(smp_valid),
      .smp_veto (smp_veto),
      .clr      (rd_done),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .fill     (fill_count),
      .full     (mem_full)
   );

   bss_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_mem (
      .clk    (clk),
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .wr_data(smp_data),
      .rd_addr(rd_addr),
      .rd_word(rd_word)
   );

   bss_serializer #(.DEPTH(DEPTH), .WORD_W(WORD_W), .MSB_FIRST(MSB_FIRST)) u_ser (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (in_rd),
      .step     (rd_ce),
      .count    (fill_count),
      .rd_word  (rd_word),
      .rd_addr  (rd_addr),
      .ser_out  (ser_out),
      .ser_frame(ser_frame),
      .done     (rd_done)
   );

   // R9
   start_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_rd && burst_start) |=> start_err);

   // R9
   start_err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_err |-> ($past(state) == ST_RD));

   // R6
   rd_fill_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_rd && !rd_done) |=> $stable(fill_count));

   // R2
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> (fill_count == '0));
endmodule

// File: tb/burst_sample_store_tb.sv
`timescale 1ns/1ps
module burst_sample_store_tb;
   localparam int DEPTH = 640;
   localparam int W     = 9;
   localparam int CW    = $clog2(DEPTH + 1);
   localparam int NV    = 6;
   // {samples[34:30], veto mask[29:14], seed[13:5], expected count[4:0]}
   localparam logic [34:0] VEC [NV] = '{
      {5'd4,  16'h0000, 9'd17,  5'd4},
      {5'd6,  16'h0002, 9'd300, 5'd5},
      {5'd5,  16'h0010, 9'd88,  5'd4},
      {5'd8,  16'h0055, 9'd511, 5'd4},
      {5'd3,  16'h0007, 9'd5,   5'd0},
      {5'd12, 16'h0800, 9'd201, 5'd11}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic burst_start = 1'b0, burst_end = 1'b0, smp_valid = 1'b0, smp_veto = 1'b0, rd_ce = 1'b0;
   logic [W-1:0] smp_data = '0;
   logic ser_out, ser_frame, mem_full, start_err;
   logic [CW-1:0] fill_count;

   int tests = 0, fails = 0;
   logic [W-1:0] model [DEPTH];
   int mptr;

   always #4 clk = ~clk;

   burst_sample_store #(.DEPTH(DEPTH), .WORD_W(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .burst_start(burst_start), .burst_end(burst_end),
      .smp_valid(smp_valid), .smp_data(smp_data), .smp_veto(smp_veto), .rd_ce(rd_ce),
      .ser_out(ser_out), .ser_frame(ser_frame), .fill_count(fill_count),
      .mem_full(mem_full), .start_err(start_err)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic pulse_start();
      @(negedge clk) burst_start = 1'b1;
      @(negedge clk) burst_start = 1'b0;
   endtask

   task automatic pulse_end();
      @(negedge clk) burst_end = 1'b1;
      @(negedge clk) burst_end = 1'b0;
   endtask

   task automatic put(input logic [W-1:0] d, input logic v, input bit accept);
      @(negedge clk) begin smp_valid = 1'b1; smp_data = d; smp_veto = v; end
      @(negedge clk) begin smp_valid = 1'b0; smp_veto = 1'b0; end
      if (accept && mptr < DEPTH) begin
         model[mptr] = d;
         if (!v) mptr++;
      end
   endtask

   task automatic step();
      @(negedge clk) rd_ce = 1'b1;
      @(negedge clk) rd_ce = 1'b0;
   endtask

   task automatic read_burst(input int n, input bit hold_chk);
      step();
      chk(ser_frame == 1'b1 && ser_out == 1'b0, "R7 marker", {ser_frame, ser_out}, 2);
      if (hold_chk) begin
         @(negedge clk);
         chk(ser_frame == 1'b1, "R7 hold", ser_frame, 1);
      end
      for (int w = 0; w < n; w++) begin
         logic [W-1:0] got = '0;
         bit frm = 1'b0;
         for (int b = 0; b < W; b++) begin
            step();
            got = {got[W-2:0], ser_out};
            frm = frm | ser_frame;
         end
         chk(got == model[w] && !frm, "R7 word", got, model[w]);
      end
      step();
      chk(!ser_frame && !ser_out && fill_count == '0, "R8 close", fill_count, 0);
   endtask

   initial begin
      #1_200_000;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(fill_count == '0 && !mem_full && !start_err && !ser_out && !ser_frame, "R1 reset", fill_count, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(fill_count == '0 && !ser_frame, "R1 after release", fill_count, 0);

      // R2: idle ignores samples and burst_end
      mptr = 0;
      put(9'h1FF, 1'b0, 1'b0);
      chk(fill_count == '0, "R2 idle sample", fill_count, 0);
      pulse_end();
      step();
      chk(!ser_frame && fill_count == '0, "R2 idle end", ser_frame, 0);

      // Table walk: R3, R4, R10
      for (int i = 0; i < NV; i++) begin
         int ns = int'(VEC[i][34:30]);
         logic [15:0] mask = VEC[i][29:14];
         logic [8:0] seed = VEC[i][13:5];
         int ex = int'(VEC[i][4:0]);
         mptr = 0;
         pulse_start();
         for (int s = 0; s < ns; s++) begin
            put(9'(int'(seed) + s * 37), mask[s], 1'b1);
            chk(int'(fill_count) == mptr, "R3/R4 count", fill_count, mptr);
         end
         chk(int'(fill_count) == ex, "R4 table count", fill_count, ex);
         pulse_end();
         read_burst(mptr, i == 0);
      end

      // R10: empty burst
      mptr = 0;
      pulse_start();
      pulse_end();
      read_burst(0, 1'b0);

      // R6 and R9
      mptr = 0;
      pulse_start();
      put(9'h0C3, 1'b0, 1'b1);
      @(negedge clk) burst_start = 1'b1;
      @(negedge clk) burst_start = 1'b0;
      chk(!start_err && fill_count == 2'd1, "R6 start in acq", start_err, 0);
      put(9'h13C, 1'b0, 1'b1);
      pulse_end();
      put(9'h055, 1'b0, 1'b0);
      chk(fill_count == CW'(2), "R6 sample in readout", fill_count, 2);
      @(negedge clk) burst_start = 1'b1;
      @(negedge clk) burst_start = 1'b0;
      chk(start_err == 1'b1, "R9 err pulse", start_err, 1);
      @(negedge clk);
      chk(start_err == 1'b0, "R9 err width", start_err, 0);
      read_burst(2, 1'b0);
      mptr = 0;
      put(9'h1AB, 1'b0, 1'b1);
      chk(fill_count == CW'(1), "R9 deferred acq", fill_count, 1);
      pulse_end();
      read_burst(1, 1'b0);

      // R5: fill to the limit
      mptr = 0;
      pulse_start();
      for (int s = 0; s < DEPTH; s++) put(9'(s) ^ 9'h0A5, 1'(s % 7 == 3 && s < 20), 1'b1);
      while (mptr < DEPTH) put(9'(mptr * 3), 1'b0, 1'b1);
      chk(int'(fill_count) == DEPTH && mem_full, "R5 full", fill_count, DEPTH);
      put(9'h000, 1'b0, 1'b1);
      put(9'h111, 1'b1, 1'b1);
      chk(int'(fill_count) == DEPTH && mem_full, "R5 no wrap", fill_count, DEPTH);
      pulse_end();
      read_burst(DEPTH, 1'b0);
      chk(!mem_full, "R8 full cleared", mem_full, 0);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule